// File: doc/BRIEF.md
# Ethernet Tunnel Link Controller

This block sits between an on-chip frame network and an Ethernet MAC and carries internal frames across an Ethernet link. It finds its remote peer through a short handshake. Until a peer is known, it sends a broadcast discovery frame once per discovery period. The remote host answers with a selection frame addressed to this node. The block stores the sender's address from that frame and confirms it with one acknowledge frame. After that, every internal frame that becomes available is wrapped into an Ethernet frame and sent to the peer.

The transmit side uses a prioritised state machine. Its choices depend on three conditions: whether a peer is known, whether the acknowledge has already gone out, and whether internal data is waiting. The receive side counts incoming bytes. It classifies a frame once the fixed check span has arrived. A frame is accepted only if it carries this node's address and the tunnel EtherType. Accepted frames either teach the peer address or pass their trailing payload bytes to a receive FIFO.

Every frame has a fixed layout. Bytes 0-5 hold the destination MAC and bytes 6-11 the source MAC, most significant byte first. Bytes 12-13 hold the EtherType 0x81FC and byte 14 holds the opcode. Bytes 15 up to CHECK_BYTES-1 (default 60) are zero padding, and any payload follows from byte CHECK_BYTES. The opcodes are 0x01 discover, 0x02 select, 0x03 acknowledge and 0x04 data. The MAC itself is replaced by plain byte streams with start and end markers.

Top module: `tunnel_link_ctrl`

## Requirements
- R1: After reset no peer is known (stored peer address all zeros), tx_valid, fifo_we and int_take are low, and no frame is sent before the first discovery period has elapsed.
- R2: While the peer address is zero, a discovery frame (destination FF:FF:FF:FF:FF:FF, source own_mac, EtherType 0x81FC, opcode 0x01, padding zero) starts once every DISC_PERIOD clock cycles when tx_ready stays high.
- R3: Every transmitted frame marks its first byte with tx_sof and its last with tx_eof. Control frames are CHECK_BYTES long and data frames are CHECK_BYTES+PAYLOAD_LEN long. tx_valid is low in the cycle after the last byte is accepted.
- R4: A byte is accepted when tx_valid and tx_ready are both high. If tx_ready is low while tx_valid is high, tx_valid is low in the next cycle, and the same byte is offered again once tx_ready returns. Frame content does not depend on stalls.
- R5: A frame carrying own_mac as destination, EtherType 0x81FC and opcode 0x02 that reaches CHECK_BYTES bytes stores its source address (bytes 6-11) as the peer. Exactly one acknowledge frame (destination = peer, opcode 0x03) follows, and discovery frames stop.
- R6: When several frames are pending, the order is: discovery (peer zero and timer fired) first, then acknowledge (peer nonzero, not yet acknowledged), then data (int_avail high).
- R7: A data frame has destination = peer latched at frame start and opcode 0x04. Its bytes from CHECK_BYTES onward are int_byte values, and int_take pulses once for each payload byte accepted.
- R8: For an accepted frame with opcode 0x04, every byte after byte CHECK_BYTES-1 is written to the FIFO in order. A byte that arrives while fifo_full is high is dropped and not written.
- R9: A frame with the wrong destination, the wrong EtherType, an unknown opcode, or fewer than CHECK_BYTES bytes writes nothing to the FIFO and leaves the peer address unchanged.
- R10: Each accepted selection frame re-arms the acknowledge, so a selection from a new peer yields a new acknowledge addressed to that peer before further data frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_mac | input | 48 | This node's MAC address |
| int_avail | input | 1 | A full internal frame of PAYLOAD_LEN bytes is waiting |
| int_byte | input | 8 | Head byte of the internal frame queue |
| int_take | output | 1 | Pops the head byte of the internal queue |
| tx_data | output | 8 | Transmit byte to the MAC |
| tx_valid | output | 1 | tx_data is valid |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | MAC accepts a byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data is valid |
| rx_sof | input | 1 | First byte of a received frame |
| rx_eof | input | 1 | Last byte of a received frame |
| fifo_wdata | output | 8 | Payload byte to the receive FIFO |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_full | input | 1 | FIFO cannot take a byte |

## Verification
On every cycle the assertions check the transmit handshake: valid drops after a refused byte, a gap follows each end of frame, internal pops occur only on accepted non-first bytes, and no FIFO write happens while the FIFO is full. They also check the quiet outputs right after reset. Only the bench scenarios can show frame content and length, the discovery period, the peer learned from a selection, a single acknowledge, the priority order when several frames are pending at once, and the rejection of malformed or short frames.

// File: rtl/tunnel_link_pkg.sv
package tunnel_link_pkg;

    typedef enum logic [1:0] {FK_DISCOVER, FK_ACK, FK_DATA} frame_kind_e;
    typedef enum logic [1:0] {TS_IDLE, TS_PREP, TS_SEND, TS_WAIT} tx_state_e;
    typedef enum logic [1:0] {RS_IDLE, RS_COUNT, RS_FWD, RS_DRAIN} rx_state_e;

    localparam logic [15:0] TUNNEL_ETYPE = 16'h81FC;
    localparam logic [7:0]  OPC_DISCOVER = 8'h01;
    localparam logic [7:0]  OPC_SELECT   = 8'h02;
    localparam logic [7:0]  OPC_ACK      = 8'h03;
    localparam logic [7:0]  OPC_DATA     = 8'h04;
    localparam logic [47:0] MAC_BCAST    = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MAC_NONE     = 48'h0;

    // Frame header as sent on the wire, first byte in the top bits
    typedef struct packed {
        logic [47:0] dst;
        logic [47:0] src;
        logic [15:0] etype;
        logic [7:0]  opc;
    } tun_hdr_t;

    localparam int HDR_W     = $bits(tun_hdr_t);
    localparam int HDR_BYTES = HDR_W / 8;

    function automatic logic [7:0] kind_opcode(frame_kind_e k);
        case (k)
            FK_DISCOVER: return OPC_DISCOVER;
            FK_ACK:      return OPC_ACK;
            default:     return OPC_DATA;
        endcase
    endfunction

    // Byte at position pos of the padded header; zero past the header
    function automatic logic [7:0] hdr_byte(tun_hdr_t h, int unsigned pos);
        logic [HDR_W-1:0] v;
        if (pos >= HDR_BYTES) return 8'h00;
        v = h;
        v = v << (8 * pos);
        return v[HDR_W-1 -: 8];
    endfunction

endpackage

// File: rtl/tunnel_disc_timer.sv
module tunnel_disc_timer #(
    parameter int PERIOD = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic pending
);
    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [TW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == TW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + TW'(1);
            if (wrap)
                pending <= 1'b1;
            else if (clr)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/tunnel_tx_engine.sv
module tunnel_tx_engine
    import tunnel_link_pkg::*;
#(
    parameter int CHECK_BYTES = 60,
    parameter int PAYLOAD_LEN = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] own_mac,
    input  logic [47:0] peer_mac,
    input  logic        peer_new,
    input  logic        disc_pend,
    output logic        disc_clr,
    input  logic        int_avail,
    input  logic [7:0]  int_byte,
    output logic        int_take,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_sof,
    output logic        tx_eof,
    input  logic        tx_ready
);
    localparam int MAXLEN = CHECK_BYTES + PAYLOAD_LEN;
    localparam int CW     = $clog2(MAXLEN + 1);

    tx_state_e   state;
    frame_kind_e kind, pick;
    logic        go;
    logic [CW-1:0] idx, rem;
    logic [47:0] dst_q;
    logic        ack_sent;
    logic        peer_known;
    logic        in_payload;
    tun_hdr_t    hdr;

    assign peer_known = (peer_mac != MAC_NONE);

    // Transmit priority: discovery, then acknowledge, then data
    always_comb begin
        go   = 1'b0;
        pick = FK_DATA;
        if (!peer_known && disc_pend) begin
            go   = 1'b1;
            pick = FK_DISCOVER;
        end else if (peer_known && !ack_sent) begin
            go   = 1'b1;
            pick = FK_ACK;
        end else if (int_avail) begin
            go   = 1'b1;
            pick = FK_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TS_IDLE;
            kind     <= FK_DISCOVER;
            idx      <= '0;
            rem      <= '0;
            dst_q    <= MAC_NONE;
            ack_sent <= 1'b0;
        end else begin
            case (state)
                TS_IDLE: begin
                    if (go) begin
                        kind  <= pick;
                        state <= TS_PREP;
                    end
                end
                TS_PREP: begin
                    idx   <= '0;
                    rem   <= (kind == FK_DATA) ? CW'(MAXLEN) : CW'(CHECK_BYTES);
                    dst_q <= (kind == FK_DISCOVER) ? MAC_BCAST : peer_mac;
                    if (kind == FK_ACK) ack_sent <= 1'b1;
                    state <= TS_SEND;
                end
                TS_SEND: begin
                    if (!tx_ready) begin
                        state <= TS_WAIT;
                    end else if (rem == CW'(1)) begin
                        state <= TS_IDLE;
                    end else begin
                        idx <= idx + CW'(1);
                        rem <= rem - CW'(1);
                    end
                end
                default: begin
                    if (tx_ready) state <= TS_SEND;
                end
            endcase
            if (peer_new) ack_sent <= 1'b0;
        end
    end

    assign hdr = '{dst: dst_q, src: own_mac, etype: TUNNEL_ETYPE, opc: kind_opcode(kind)};
    assign in_payload = (idx >= CW'(CHECK_BYTES));

    assign tx_valid = (state == TS_SEND);
    assign tx_data  = in_payload ? int_byte : hdr_byte(hdr, 32'(idx));
    assign tx_sof   = tx_valid && (idx == '0);
    assign tx_eof   = tx_valid && (rem == CW'(1));
    assign int_take = tx_valid && tx_ready && in_payload;
    assign disc_clr = (state == TS_PREP) && (kind == FK_DISCOVER);
endmodule

// File: rtl/tunnel_rx_parser.sv
module tunnel_rx_parser
    import tunnel_link_pkg::*;
#(
    parameter int CHECK_BYTES = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] own_mac,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        fifo_full,
    output logic [7:0]  fifo_wdata,
    output logic        fifo_we,
    output logic [47:0] peer_mac,
    output logic        peer_new
);
    localparam int CW = $clog2(CHECK_BYTES + 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [HDR_W-1:0]  hdr_sh, hdr_nx;
    tun_hdr_t          hv;
    logic              hit, is_sel, is_data, at_check;

    // Shift header bytes in until the header is complete
    assign hdr_nx   = (cnt < CW'(HDR_BYTES)) ? {hdr_sh[HDR_W-9:0], rx_data} : hdr_sh;
    assign hv       = tun_hdr_t'(hdr_nx);
    assign hit      = (hv.dst == own_mac) && (hv.etype == TUNNEL_ETYPE);
    assign is_sel   = hit && (hv.opc == OPC_SELECT);
    assign is_data  = hit && (hv.opc == OPC_DATA);
    assign at_check = (state == RS_COUNT) && rx_valid && (cnt == CW'(CHECK_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RS_IDLE;
            cnt      <= '0;
            hdr_sh   <= '0;
            peer_mac <= MAC_NONE;
            peer_new <= 1'b0;
        end else begin
            peer_new <= 1'b0;
            case (state)
                RS_IDLE: begin
                    if (rx_valid && rx_sof) begin
                        hdr_sh <= hdr_nx;
                        if (!rx_eof) begin
                            cnt   <= CW'(1);
                            state <= RS_COUNT;
                        end
                    end
                end
                RS_COUNT: begin
                    if (rx_valid) begin
                        hdr_sh <= hdr_nx;
                        if (at_check) begin
                            cnt <= '0;
                            if (is_sel) begin
                                peer_mac <= hv.src;
                                peer_new <= 1'b1;
                            end
                            if (rx_eof)       state <= RS_IDLE;
                            else if (is_data) state <= RS_FWD;
                            else              state <= RS_DRAIN;
                        end else if (rx_eof) begin
                            cnt   <= '0;
                            state <= RS_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                default: begin
                    if (rx_valid && rx_eof) state <= RS_IDLE;
                end
            endcase
        end
    end

    assign fifo_wdata = rx_data;
    assign fifo_we    = (state == RS_FWD) && rx_valid && !fifo_full;
endmodule

// File: rtl/tunnel_link_ctrl.sv
module tunnel_link_ctrl
    import tunnel_link_pkg::*;
#(
    parameter int DISC_PERIOD = 250_000_000,
    parameter int CHECK_BYTES = 60,
    parameter int PAYLOAD_LEN = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] own_mac,
    input  logic        int_avail,
    input  logic [7:0]  int_byte,
    output logic        int_take,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_sof,
    output logic        tx_eof,
    input  logic        tx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    output logic [7:0]  fifo_wdata,
    output logic        fifo_we,
    input  logic        fifo_full
);
    logic        disc_pend, disc_clr;
    logic [47:0] peer_mac;
    logic        peer_new;

    tunnel_disc_timer #(.PERIOD(DISC_PERIOD)) u_timer (
        .clk(clk), .rst(rst), .clr(disc_clr), .pending(disc_pend)
    );

    tunnel_tx_engine #(.CHECK_BYTES(CHECK_BYTES), .PAYLOAD_LEN(PAYLOAD_LEN)) u_tx (
        .clk(clk), .rst(rst), .own_mac(own_mac), .peer_mac(peer_mac),
        .peer_new(peer_new), .disc_pend(disc_pend), .disc_clr(disc_clr),
        .int_avail(int_avail), .int_byte(int_byte), .int_take(int_take),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_ready(tx_ready)
    );

    tunnel_rx_parser #(.CHECK_BYTES(CHECK_BYTES)) u_rx (
        .clk(clk), .rst(rst), .own_mac(own_mac), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .fifo_full(fifo_full), .fifo_wdata(fifo_wdata), .fifo_we(fifo_we),
        .peer_mac(peer_mac), .peer_new(peer_new)
    );
endmodule

// File: rtl/tunnel_link_checker.sv
module tunnel_link_checker (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_sof,
    input logic tx_eof,
    input logic int_take,
    input logic fifo_we,
    input logic fifo_full,
    input logic rx_valid
);
    // R1: outputs quiet in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && !fifo_we && !int_take));

    // R4: a refused byte withdraws valid for one cycle
    p_stall_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> !tx_valid);

    // R3: a gap follows each accepted last byte
    p_eof_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_eof) |=> !tx_valid);

    // R7: internal pops only on accepted payload bytes
    p_take_on_xfer_r7: assert property (@(posedge clk) disable iff (rst)
        int_take |-> (tx_valid && tx_ready && !tx_sof));

    // R8: never write a full FIFO, never write without a received byte
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_we |-> (!fifo_full && rx_valid));
endmodule

bind tunnel_link_ctrl tunnel_link_checker u_chk (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .int_take(int_take),
    .fifo_we(fifo_we), .fifo_full(fifo_full), .rx_valid(rx_valid)
);

// File: tb/tunnel_link_ctrl_bench.sv
module tunnel_link_ctrl_bench;
    localparam int PERIOD = 300;
    localparam int CHK    = 60;
    localparam int PAY    = 4;
    localparam logic [47:0] OWN   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MAC_A = 48'h0A_0B_0C_0D_0E_01;
    localparam logic [47:0] MAC_B = 48'h0A_0B_0C_0D_0E_02;
    localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] int_byte;
    logic int_avail, int_take;
    logic [7:0] tx_data;
    logic tx_valid, tx_sof, tx_eof;
    logic tx_ready = 1'b1;
    logic [7:0] rx_data = 8'h00;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0] fifo_wdata;
    logic fifo_we;
    logic fifo_full = 1'b0;

    int nchk = 0, nerr = 0, cyc = 0;
    bit hold_ready = 0, stall_mode = 0;

    logic [7:0] qbuf [0:63];
    int qhead = 0, qtail = 0;
    logic [7:0] fb [0:31][0:127];
    int fr_len [0:31];
    int sof_cyc [0:31];
    int nfr = 0, cur_len = 0, stall_viol = 0;
    bit stall_seen = 0;
    logic [7:0] fq [0:63];
    int nfq = 0;

    always #2 clk = ~clk;

    tunnel_link_ctrl #(.DISC_PERIOD(PERIOD), .CHECK_BYTES(CHK), .PAYLOAD_LEN(PAY)) u_tunnel_link_ctrl (
        .clk(clk), .rst(rst), .own_mac(OWN), .int_avail(int_avail), .int_byte(int_byte),
        .int_take(int_take), .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .fifo_wdata(fifo_wdata), .fifo_we(fifo_we),
        .fifo_full(fifo_full)
    );

    assign int_byte  = qbuf[qhead[5:0]];
    assign int_avail = (qtail - qhead) >= PAY;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (int_take) qhead <= qhead + 1;
    end

    always @(posedge clk) begin
        #1;
        tx_ready = hold_ready ? 1'b0 : (stall_mode ? (cyc % 3 != 1) : 1'b1);
    end

    // Monitor away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_seen && tx_valid) stall_viol++;
            if (tx_valid && tx_ready && nfr < 32) begin
                if (tx_sof) begin cur_len = 0; sof_cyc[nfr] = cyc; end
                if (cur_len < 128) fb[nfr][cur_len] = tx_data;
                cur_len++;
                if (tx_eof) begin fr_len[nfr] = cur_len; nfr++; end
            end
            stall_seen = tx_valid && !tx_ready;
            if (fifo_we && nfq < 64) begin fq[nfq] = fifo_wdata; nfq++; end
        end
    end

    task automatic check(input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(logic [47:0] dst, logic [7:0] op, int i);
        if (i < 6)  return dst[47-8*i -: 8];
        if (i < 12) return OWN[47-8*(i-6) -: 8];
        if (i == 12) return 8'h81;
        if (i == 13) return 8'hFC;
        if (i == 14) return op;
        return 8'h00;
    endfunction

    task automatic chk_frame(input int k, input logic [47:0] dst, input logic [7:0] op,
                             input int len, input int pbase, input string tag);
        int bad = 0;
        logic [47:0] got_dst = '0;
        for (int i = 0; i < 6; i++) got_dst = {got_dst[39:0], fb[k][i]};
        check({tag, " frame length"}, fr_len[k], len);
        check({tag, " destination"}, got_dst, dst);
        for (int i = 0; i < CHK; i++) if (fb[k][i] != exp_byte(dst, op, i)) bad++;
        check({tag, " header/padding mismatches"}, bad, 0);
        if (len > CHK) begin
            bad = 0;
            for (int p = 0; p < PAY; p++) if (fb[k][CHK+p] != 8'(8'h30 + pbase + p)) bad++;
            check({tag, " payload mismatches"}, bad, 0);
        end
    endtask

    task automatic push_int(input int n);
        for (int i = 0; i < n; i++) qbuf[(qtail + i) % 64] = 8'(8'h30 + qtail + i);
        qtail = qtail + n;
    endtask

    task automatic wait_frames(input int n);
        while (nfr < n) @(posedge clk);
        #1;
    endtask

    task automatic send_rx(input logic [47:0] dst, input logic [47:0] src, input logic [15:0] et,
                           input logic [7:0] op, input int total, input logic [7:0] pbase,
                           input int flo, input int fhi);
        for (int i = 0; i < total; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == total - 1);
            if (i < 6)        rx_data = dst[47-8*i -: 8];
            else if (i < 12)  rx_data = src[47-8*(i-6) -: 8];
            else if (i == 12) rx_data = et[15:8];
            else if (i == 13) rx_data = et[7:0];
            else if (i == 14) rx_data = op;
            else if (i < CHK) rx_data = 8'h00;
            else              rx_data = pbase + 8'(i - CHK);
            fifo_full = (i - CHK >= flo) && (i - CHK <= fhi);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; fifo_full = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual %0d frames expected progress", nfr);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int k;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 tx_valid after reset", tx_valid, 0);
        check("R1 fifo_we after reset", fifo_we, 0);
        check("R1 int_take after reset", int_take, 0);
        repeat (250) @(posedge clk);
        check("R1 no frame before first period", nfr, 0);

        // R2: periodic discovery while no peer is known
        wait_frames(2);
        chk_frame(0, BCAST, 8'h01, CHK, 0, "R2 disc0");
        chk_frame(1, BCAST, 8'h01, CHK, 0, "R2 disc1");
        check("R2 discovery spacing", sof_cyc[1] - sof_cyc[0], PERIOD);

        // R4/R6: stall a discovery across a period while data arrives
        hold_ready = 1;
        repeat (700) @(posedge clk);
        #1 push_int(PAY);
        hold_ready = 0;
        wait_frames(5);
        chk_frame(2, BCAST, 8'h01, CHK, 0, "R4 stalled discovery");
        chk_frame(3, BCAST, 8'h01, CHK, 0, "R6 discovery before data");
        chk_frame(4, 48'h0, 8'h04, CHK + PAY, 0, "R7 data with no peer");

        // R9: rejected frames
        send_rx(OWN, MAC_A, 16'h0800, 8'h02, CHK, 8'h00, 100, 99);
        send_rx(OTHER, MAC_A, 16'h81FC, 8'h02, CHK, 8'h00, 100, 99);
        send_rx(OWN, MAC_A, 16'h81FC, 8'h02, 40, 8'h00, 100, 99);
        send_rx(OWN, MAC_A, 16'h81FC, 8'h07, CHK, 8'h00, 100, 99);
        send_rx(OTHER, MAC_A, 16'h81FC, 8'h04, CHK + 5, 8'h60, 100, 99);
        send_rx(OWN, MAC_A, 16'h81FC, 8'h04, 30, 8'h60, 100, 99);
        check("R9 no FIFO writes from rejected frames", nfq, 0);
        k = nfr;
        wait_frames(k + 2);
        chk_frame(k + 1, BCAST, 8'h01, CHK, 0, "R9 peer still unknown");

        // R5: selection learns peer, one acknowledge
        send_rx(OWN, MAC_A, 16'h81FC, 8'h02, CHK, 8'h00, 100, 99);
        k = nfr;
        wait_frames(k + 1);
        chk_frame(k, MAC_A, 8'h03, CHK, 0, "R5 acknowledge");
        repeat (700) @(posedge clk);
        check("R5 single acknowledge, discovery stopped", nfr, k + 1);

        // R8: data frame into FIFO with full window on payload bytes 2..3
        send_rx(OWN, OTHER, 16'h81FC, 8'h04, CHK + 8, 8'h50, 2, 3);
        check("R8 FIFO write count", nfq, 6);
        check("R8 fifo byte 0", fq[0], 8'h50);
        check("R8 fifo byte 1", fq[1], 8'h51);
        check("R8 fifo byte 2 after drop", fq[2], 8'h54);
        check("R8 fifo byte 5", fq[5], 8'h57);

        // R6/R10: new selection during a stalled data frame
        hold_ready = 1;
        push_int(PAY);
        repeat (10) @(posedge clk);
        #1 push_int(PAY);
        send_rx(OWN, MAC_B, 16'h81FC, 8'h02, CHK, 8'h00, 100, 99);
        stall_mode = 1;
        hold_ready = 0;
        k = nfr;
        wait_frames(k + 3);
        chk_frame(k, MAC_A, 8'h04, CHK + PAY, 4, "R7 data to first peer");
        chk_frame(k + 1, MAC_B, 8'h03, CHK, 0, "R10 re-acknowledge before data R6");
        chk_frame(k + 2, MAC_B, 8'h04, CHK + PAY, 8, "R4 data under ready pattern");
        check("R7 internal queue fully consumed", qtail - qhead, 0);
        check("R4 valid held after refused byte", stall_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule